// File: doc/BRIEF.md
# GPIO Port Register Bank

A word-addressed register bank for a 32-pin general-purpose I/O port. It holds the port output levels, the port direction bits and one 32-bit configuration word per pin. These values are presented in parallel to the pin logic. The pin logic returns the sampled pad levels on a 32-bit input bus, and software can read them back.

The output and direction registers each have three write addresses. One replaces the whole register, one sets the bits that are 1 in the write data, and one clears the bits that are 1 in the write data. This lets software change single pins without a read-modify-write sequence. Direction lives both in the port-wide direction register and in bit 0 of every pin's configuration word. A write through either path updates the other, so both views always agree.

The bus carries full 32-bit words only. A request is a single-cycle pulse on `req_i`, qualified by `we_i`. Writes take effect on the edge that accepts them. Read data and the error flag appear one cycle later.

Top module: `gpio_regbank`

## Requirements
- R1: A write to 0x504 replaces the output register. A write to 0x508 ORs the data into it. A write to 0x50C clears every output bit whose data bit is 1. The new value is visible on `out_o` right after the accepting edge.
- R2: Writes to 0x514, 0x518 and 0x51C apply the same replace, OR-set and AND-NOT-clear rules to the direction register driven on `dir_o`.
- R3: A read at any of 0x504, 0x508 or 0x50C returns the output register. A read at any of 0x514, 0x518 or 0x51C returns the direction register. Read data appears on `rdata_o` in the cycle after the request.
- R4: After any direction write, bit 0 of every pin's configuration word equals that pin's direction bit. Bits 31:1 of the configuration words are unchanged.
- R5: A write to the configuration word of pin n stores all 32 bits and copies data bit 0 into bit n of the direction register.
- R6: The configuration words sit at 0x700 + 4·n for n = 0..31. Pin n's word is driven on `cnf_o[32n+31:32n]` and is readable at that address.
- R7: After reset, the output register and the direction register are 0, and every configuration word is 0x00000002.
- R8: An access to an unmapped or non-word-aligned address changes no register and reads as 0. `err_o` is high for exactly the one cycle after that request.
- R9: A read at 0x510 returns `in_i` as registered one edge earlier. This register reads 0 after reset. A write to 0x510 changes no register and does not raise `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address within the bank |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| err_o | output | 1 | One-cycle flag for an unmapped or misaligned access |
| in_i | input | 32 | Pad levels from the pin logic |
| out_o | output | 32 | Output levels to the pin logic |
| dir_o | output | 32 | Direction bits to the pin logic, 1 = output |
| cnf_o | output | 1024 | Configuration words, pin n at bits 32n+31:32n |

## Verification
Every stored bit reaches a port directly, so a wrong internal state cannot stay hidden. A bad alias update, a lost mirror bit or a misrouted configuration write shows on `out_o`, `dir_o` or `cnf_o` right after the edge that accepted the write. The same state is then read back through `rdata_o` one cycle later. A mirror fault is visible from both sides: a configuration write is checked on `dir_o`, and a direction write is checked on bit 0 of the matching `cnf_o` word. The decode path is exercised at the array ends (pins 0 and 31), just past the array, and at misaligned and read-only addresses. For these, `err_o` and unchanged outputs are checked in the very next cycle.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_OUT      = 12'h504;
  localparam logic [ADDR_W-1:0] OFF_OUTSET   = 12'h508;
  localparam logic [ADDR_W-1:0] OFF_OUTCLR   = 12'h50C;
  localparam logic [ADDR_W-1:0] OFF_IN       = 12'h510;
  localparam logic [ADDR_W-1:0] OFF_DIR      = 12'h514;
  localparam logic [ADDR_W-1:0] OFF_DIRSET   = 12'h518;
  localparam logic [ADDR_W-1:0] OFF_DIRCLR   = 12'h51C;
  localparam logic [ADDR_W-1:0] OFF_CNF_BASE = 12'h700;

  localparam logic [DATA_W-1:0] CNF_RESET = 32'h0000_0002;

  typedef enum logic [1:0] {OP_NONE, OP_LOAD, OP_SET, OP_CLR} alias_op_e;
  typedef enum logic [2:0] {SEL_NONE, SEL_OUT, SEL_IN, SEL_DIR, SEL_CNF} rd_sel_e;

  typedef struct packed {
    alias_op_e out_op;
    alias_op_e dir_op;
    logic      cnf_we;
    rd_sel_e   sel;
    logic      hit;
  } dec_t;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  localparam int unsigned IDX_W = $clog2(NUM_PINS)
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o,
  output logic [IDX_W-1:0]  cnf_idx_o
);
  localparam logic [ADDR_W-3:0] NPINS = (ADDR_W-2)'(NUM_PINS);

  logic [ADDR_W-1:0] cnf_off;
  logic              wr;

  assign cnf_off   = addr_i - OFF_CNF_BASE;
  assign cnf_idx_o = cnf_off[IDX_W+1:2];
  assign wr        = req_i && we_i;

  always_comb begin
    dec_o        = '0;
    dec_o.out_op = OP_NONE;
    dec_o.dir_op = OP_NONE;
    dec_o.sel    = SEL_NONE;
    unique case (addr_i)
      OFF_OUT:    begin dec_o.sel = SEL_OUT; dec_o.hit = 1'b1; if (wr) dec_o.out_op = OP_LOAD; end
      OFF_OUTSET: begin dec_o.sel = SEL_OUT; dec_o.hit = 1'b1; if (wr) dec_o.out_op = OP_SET;  end
      OFF_OUTCLR: begin dec_o.sel = SEL_OUT; dec_o.hit = 1'b1; if (wr) dec_o.out_op = OP_CLR;  end
      OFF_IN:     begin dec_o.sel = SEL_IN;  dec_o.hit = 1'b1; end
      OFF_DIR:    begin dec_o.sel = SEL_DIR; dec_o.hit = 1'b1; if (wr) dec_o.dir_op = OP_LOAD; end
      OFF_DIRSET: begin dec_o.sel = SEL_DIR; dec_o.hit = 1'b1; if (wr) dec_o.dir_op = OP_SET;  end
      OFF_DIRCLR: begin dec_o.sel = SEL_DIR; dec_o.hit = 1'b1; if (wr) dec_o.dir_op = OP_CLR;  end
      default: begin
        if (addr_i >= OFF_CNF_BASE && cnf_off[1:0] == 2'b00 &&
            cnf_off[ADDR_W-1:2] < NPINS) begin
          dec_o.sel    = SEL_CNF;
          dec_o.hit    = 1'b1;
          dec_o.cnf_we = wr;
        end
      end
    endcase
  end
endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned  W   = 32,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  alias_op_e    op_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] bit_we_i,   // per-bit load from another path
  input  logic [W-1:0] bit_val_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_n;

  always_comb begin
    unique case (op_i)
      OP_LOAD: q_n = wdata_i;
      OP_SET:  q_n = q_q | wdata_i;
      OP_CLR:  q_n = q_q & ~wdata_i;
      default: q_n = q_q;
    endcase
    q_n = (q_n & ~bit_we_i) | (bit_val_i & bit_we_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q_q <= RST;
    else         q_q <= q_n;

  assign q_o = q_q;
endmodule

// File: rtl/gpio_cnf_bank.sv
module gpio_cnf_bank
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  localparam int unsigned IDX_W = $clog2(NUM_PINS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [DATA_W-1:1]          wdata_i,
  input  logic [NUM_PINS-1:0]        dir_i,
  output logic [NUM_PINS*DATA_W-1:0] cnf_o
);
  // bit 0 is not stored here: it is the pin's direction bit
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [DATA_W-1:1] hi_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                              hi_q <= CNF_RESET[DATA_W-1:1];
      else if (we_i && idx_i == IDX_W'(p))      hi_q <= wdata_i;
    assign cnf_o[p*DATA_W +: DATA_W] = {hi_q, dir_i[p]};
  end
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic                       err_o,
  input  logic [NUM_PINS-1:0]        in_i,
  output logic [NUM_PINS-1:0]        out_o,
  output logic [NUM_PINS-1:0]        dir_o,
  output logic [NUM_PINS*DATA_W-1:0] cnf_o
);
  localparam int unsigned IDX_W = $clog2(NUM_PINS);

  dec_t                dec;
  logic [IDX_W-1:0]    cnf_idx;
  logic [NUM_PINS-1:0] in_q, dir_bit_we;
  logic [DATA_W-1:0]   rd_val, rdata_q;
  logic                err_q;

  gpio_addr_decode #(.NUM_PINS(NUM_PINS)) u_dec (
    .req_i, .we_i, .addr_i, .dec_o(dec), .cnf_idx_o(cnf_idx)
  );

  gpio_alias_reg #(.W(NUM_PINS)) u_out (
    .clk_i, .rst_ni, .op_i(dec.out_op), .wdata_i(wdata_i[NUM_PINS-1:0]),
    .bit_we_i('0), .bit_val_i('0), .q_o(out_o)
  );

  // a configuration write loads one direction bit
  assign dir_bit_we = dec.cnf_we ? (NUM_PINS'(1) << cnf_idx) : '0;

  gpio_alias_reg #(.W(NUM_PINS)) u_dir (
    .clk_i, .rst_ni, .op_i(dec.dir_op), .wdata_i(wdata_i[NUM_PINS-1:0]),
    .bit_we_i(dir_bit_we), .bit_val_i({NUM_PINS{wdata_i[0]}}), .q_o(dir_o)
  );

  gpio_cnf_bank #(.NUM_PINS(NUM_PINS)) u_cnf (
    .clk_i, .rst_ni, .we_i(dec.cnf_we), .idx_i(cnf_idx),
    .wdata_i(wdata_i[DATA_W-1:1]), .dir_i(dir_o), .cnf_o
  );

  always_comb begin
    unique case (dec.sel)
      SEL_OUT: rd_val = DATA_W'(out_o);
      SEL_IN:  rd_val = DATA_W'(in_q);
      SEL_DIR: rd_val = DATA_W'(dir_o);
      SEL_CNF: rd_val = cnf_o[cnf_idx*DATA_W +: DATA_W];
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      in_q    <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      in_q    <= in_i;
      rdata_q <= (req_i && !we_i) ? rd_val : '0;
      err_q   <= req_i && !dec.hit;
    end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;
endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       req_i,
  input logic                       we_i,
  input logic [ADDR_W-1:0]          addr_i,
  input logic [DATA_W-1:0]          wdata_i,
  input logic [DATA_W-1:0]          rdata_o,
  input logic                       err_o,
  input logic [NUM_PINS-1:0]        out_o,
  input logic [NUM_PINS-1:0]        dir_o,
  input logic [NUM_PINS*DATA_W-1:0] cnf_o
);
  localparam int unsigned IDX_W = $clog2(NUM_PINS);

  logic              wr;
  logic [ADDR_W-1:0] coff;
  logic              cnf_wr, cnf_wr_q;
  logic [IDX_W-1:0]  cidx_q;
  logic [DATA_W-1:0] cdat_q;

  assign wr     = req_i && we_i;
  assign coff   = addr_i - OFF_CNF_BASE;
  assign cnf_wr = wr && addr_i >= OFF_CNF_BASE && coff[1:0] == 2'b00 &&
                  coff < ADDR_W'(NUM_PINS * 4);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnf_wr_q <= 1'b0;
      cidx_q   <= '0;
      cdat_q   <= '0;
    end else begin
      cnf_wr_q <= cnf_wr;
      cidx_q   <= coff[IDX_W+1:2];
      cdat_q   <= wdata_i;
    end

  assert_outset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFF_OUTSET) |=> out_o == ($past(out_o) | $past(wdata_i[NUM_PINS-1:0])));
  assert_outclr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFF_OUTCLR) |=> out_o == ($past(out_o) & ~$past(wdata_i[NUM_PINS-1:0])));
  assert_dir_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFF_DIR) |=> dir_o == $past(wdata_i[NUM_PINS-1:0]));
  assert_dirset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFF_DIRSET) |=> dir_o == ($past(dir_o) | $past(wdata_i[NUM_PINS-1:0])));
  assert_dirclr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFF_DIRCLR) |=> dir_o == ($past(dir_o) & ~$past(wdata_i[NUM_PINS-1:0])));
  assert_cnf_store_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnf_wr_q |-> (cnf_o[cidx_q*DATA_W +: DATA_W] == cdat_q && dir_o[cidx_q] == cdat_q[0]));
  assert_err_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rdata_o == '0);
  assert_err_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i));
  assert_in_wr_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFF_IN) |=> ($stable(out_o) && $stable(dir_o) && $stable(cnf_o) && !err_o));
endmodule

bind gpio_regbank gpio_regbank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .err_o(err_o), .out_o(out_o),
  .dir_o(dir_o), .cnf_o(cnf_o)
);

// File: tb/gpio_regbank_bench.sv
module gpio_regbank_bench;
  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic          we_i = 1'b0;
  logic [11:0]   addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic          err_o;
  logic [31:0]   in_i = '0;
  logic [31:0]   out_o, dir_o;
  logic [1023:0] cnf_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  gpio_regbank u_gpio_regbank (.*);

  always #4 clk_i = ~clk_i;

  function automatic logic [31:0] cnf(int p);
    return cnf_o[p*32 +: 32];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d, output logic e);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
    d = rdata_o; e = err_o;
  endtask

  task automatic t_reset;
    chk("R7 out", out_o, 32'h0);
    chk("R7 dir", dir_o, 32'h0);
    for (int p = 0; p < 32; p++) chk("R7 cnf", cnf(p), 32'h2);
  endtask

  task automatic t_out;
    logic [31:0] d; logic e;
    wr(12'h504, 32'hA5A5_0F0F); chk("R1 replace", out_o, 32'hA5A5_0F0F);
    wr(12'h508, 32'h0F00_0000); chk("R1 set", out_o, 32'hAFA5_0F0F);
    wr(12'h50C, 32'h0000_0005); chk("R1 clear", out_o, 32'hAFA5_0F0A);
    rd(12'h50C, d, e); chk("R3 read outclr", d, 32'hAFA5_0F0A);
    chk("R3 no err", {31'b0, e}, 32'h0);
    rd(12'h508, d, e); chk("R3 read outset", d, 32'hAFA5_0F0A);
  endtask

  task automatic t_dir;
    logic [31:0] d; logic e;
    wr(12'h714, 32'hABCD_0004);
    chk("R5 cnf5", cnf(5), 32'hABCD_0004);
    wr(12'h514, 32'h0000_FF00);
    chk("R2 replace", dir_o, 32'h0000_FF00);
    chk("R4 cnf8", cnf(8), 32'h3);
    chk("R4 cnf0", cnf(0), 32'h2);
    chk("R4 cnf5 kept", cnf(5), 32'hABCD_0004);
    wr(12'h518, 32'h0000_0020);
    chk("R2 set", dir_o, 32'h0000_FF20);
    chk("R4 cnf5 bit0", cnf(5), 32'hABCD_0005);
    wr(12'h51C, 32'h0000_0100);
    chk("R2 clear", dir_o, 32'h0000_FE20);
    chk("R4 cnf8 clr", cnf(8), 32'h2);
    rd(12'h518, d, e); chk("R3 read dirset", d, 32'h0000_FE20);
    rd(12'h51C, d, e); chk("R3 read dirclr", d, 32'h0000_FE20);
  endtask

  task automatic t_cnf;
    logic [31:0] d; logic e;
    wr(12'h77C, 32'h0003_0001);
    chk("R6 cnf31", cnf(31), 32'h0003_0001);
    chk("R5 dir31", dir_o, 32'h8000_FE20);
    rd(12'h77C, d, e); chk("R6 read cnf31", d, 32'h0003_0001);
    wr(12'h724, 32'hFFFF_FFFE);
    chk("R5 dir9 clr", dir_o, 32'h8000_FC20);
    chk("R6 cnf9", cnf(9), 32'hFFFF_FFFE);
    rd(12'h71C, d, e); chk("R6 read cnf7", d, 32'h2);
    rd(12'h700, d, e); chk("R6 read cnf0", d, 32'h2);
  endtask

  task automatic t_bad;
    logic [31:0] d; logic e;
    rd(12'h780, d, e);
    chk("R8 rd past array data", d, 32'h0);
    chk("R8 err", {31'b0, e}, 32'h1);
    @(negedge clk_i); chk("R8 err one cycle", {31'b0, err_o}, 32'h0);
    wr(12'h500, 32'hFFFF_FFFF);
    chk("R8 wr err", {31'b0, err_o}, 32'h1);
    chk("R8 out kept", out_o, 32'hAFA5_0F0A);
    chk("R8 dir kept", dir_o, 32'h8000_FC20);
    wr(12'h506, 32'h0);
    chk("R8 misaligned err", {31'b0, err_o}, 32'h1);
    chk("R8 misaligned out", out_o, 32'hAFA5_0F0A);
    wr(12'h702, 32'h0);
    chk("R8 misaligned cnf", cnf(0), 32'h2);
    wr(12'h510, 32'hFFFF_FFFF);
    chk("R9 in wr no err", {31'b0, err_o}, 32'h0);
    chk("R9 in wr out", out_o, 32'hAFA5_0F0A);
    chk("R9 in wr dir", dir_o, 32'h8000_FC20);
    in_i = 32'h1234_5678;
    @(negedge clk_i); @(negedge clk_i);
    rd(12'h510, d, e); chk("R9 in read", d, 32'h1234_5678);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_out();
    t_dir();
    t_cnf();
    t_bad();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule